// File: doc/BRIEF.md
# Serial Command Shift Interface

This block is the serial front end of a four-channel DAC control chip. A host drives a serial clock, an active-low select and a data line. While the select is low, the block samples the data line on each rising serial-clock edge, most significant bit first, into a 12-bit shift register. When the select returns high, the register contents go to the command decoder as one word: two address bits, then two control bits, then eight data bits. A one-cycle valid strobe marks the word.

The block also drives a serial output for daisy-chaining. The output repeats the input stream 12 serial clocks later. The decoder chooses at run time whether the output changes on the falling edge (the default) or on the rising edge of the serial clock. The output is always driven and holds its level between transfers.

The serial pins are asynchronous to the block. The block runs on a system clock. It passes the serial pins through a synchroniser and finds their edges by comparing each sample with the one before. The serial clock must therefore run well below the system clock. The select and the serial clock pass through identical synchroniser stages, so their relative order is preserved.

Top module: `cmd_shift_if`

## Requirements
- R1: After reset, `doutOut` is 0, `cmdValid` is 0 and the falling-edge output mode is selected. The shift register is all zeros, so a transfer with no serial clocks yields word 0x000.
- R2: A bit is taken from `dinIn` only on a rising `sclkIn` edge while `csNIn` is low. Serial-clock edges while `csNIn` is high change neither the shift register nor `doutOut`.
- R3: `cmdWord` holds the last 12 bits received, with the earliest of them in bit 11. Bits 11:10 are the address, bits 9:8 are the control and bits 7:0 are the data. In a 16-bit transfer, the first four bits drop out.
- R4: Every rising edge of `csNIn` presents the current shift-register contents on `cmdWord`, even if fewer than 12 bits were clocked. Bits from earlier transfers fill the rest of the word.
- R5: `cmdValid` is high for exactly one system-clock cycle after each rising edge of `csNIn`. `cmdWord` changes only in that cycle.
- R6: In rising-edge mode (mode value 1), the bit taken on rising edge n appears on `doutOut` at rising edge n+12. Falling edges do not change `doutOut` in this mode.
- R7: In falling-edge mode (mode value 0), the bit taken on rising edge n appears on `doutOut` at the falling edge that follows rising edge n+12. Rising edges do not change `doutOut` in this mode.
- R8: `doutOut` is always driven and keeps its level while `csNIn` is high or `sclkIn` is idle.
- R9: A cycle with `modeSetValid` high loads `modeSetValue` as the output mode: 0 selects falling edge, 1 selects rising edge. The mode persists until the next such cycle.
- R10: The shift register keeps its contents across transfers. Before a transfer has ejected any bits of its own, `doutOut` carries bits of the previous traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, asynchronous |
| csNIn | input | 1 | Active-low select, asynchronous |
| dinIn | input | 1 | Serial data in, asynchronous |
| modeSetValid | input | 1 | Load a new output-edge mode this cycle |
| modeSetValue | input | 1 | New mode: 0 falling edge, 1 rising edge |
| cmdValid | output | 1 | One-cycle strobe for a completed command |
| cmdWord | output | 12 | Captured command word, address in bits 11:10 |
| doutOut | output | 1 | Serial data out, input delayed by 12 clocks |

## Verification
The bench sends transfers of 0, 4, 8, 12 and 16 bits. It checks that short transfers combine with bits left over from earlier traffic and that long transfers keep only the last twelve bits. A design that clears the register between transfers, or that keeps the first bits of a transfer, returns a wrong word.

The output is checked after every half serial-clock period in both modes and across a mode switch. An echo taken from the wrong edge or with the wrong delay shows up half a clock or a whole bit out of place.

Clock toggling with the select high, and a transfer with no clocks, expose a design that samples while deselected or that drops the strobe for an empty transfer. Counting strobe cycles catches a design whose valid pulse is longer than one cycle.

// File: rtl/cmdsh_pkg.sv
package cmdsh_pkg;
  localparam int CMD_BITS = 12;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } doutEdgeT;

  typedef struct packed {
    logic shiftEn;
    logic fallEn;
    logic csRise;
  } strbT;
endpackage

// File: rtl/cmdsh_sync.sv
module cmdsh_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RESET_VAL;
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/cmdsh_ctrl.sv
module cmdsh_ctrl import cmdsh_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic sclkS,
  input  logic csNS,
  output strbT strb
);
  logic sclkPrev;
  logic csNPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csNPrev  <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csNPrev  <= csNS;
    end
  end

  always_comb begin
    strb.shiftEn = sclkS & ~sclkPrev & ~csNS;
    strb.fallEn  = ~sclkS & sclkPrev & ~csNS;
    strb.csRise  = csNS & ~csNPrev;
  end
endmodule

// File: rtl/cmdsh_dpath.sv
module cmdsh_dpath import cmdsh_pkg::*; #(
  parameter int WORD_BITS = CMD_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strbT                 strb,
  input  logic                 dinS,
  input  logic                 modeSetValid,
  input  logic                 modeSetValue,
  output doutEdgeT             modeQ,
  output logic                 cmdValid,
  output logic [WORD_BITS-1:0] cmdWord,
  output logic                 doutOut
);
  localparam int TOP = WORD_BITS - 1;

  logic [WORD_BITS-1:0] shiftReg;
  logic                 ejectReg;
  logic                 doutLoad;
  logic                 doutNext;

  always_comb begin
    if (modeQ == EDGE_RISE) begin
      doutLoad = strb.shiftEn;
      doutNext = shiftReg[TOP];
    end else begin
      doutLoad = strb.fallEn;
      doutNext = ejectReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ejectReg <= 1'b0;
      modeQ    <= EDGE_FALL;
      doutOut  <= 1'b0;
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      if (strb.shiftEn) begin
        shiftReg <= {shiftReg[TOP-1:0], dinS};
        ejectReg <= shiftReg[TOP];
      end
      if (modeSetValid) modeQ <= doutEdgeT'(modeSetValue);
      if (doutLoad) doutOut <= doutNext;
      cmdValid <= strb.csRise;
      if (strb.csRise) cmdWord <= shiftReg;
    end
  end
endmodule

// File: rtl/cmd_shift_if.sv
module cmd_shift_if import cmdsh_pkg::*; #(
  parameter int WORD_BITS = CMD_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 csNIn,
  input  logic                 dinIn,
  input  logic                 modeSetValid,
  input  logic                 modeSetValue,
  output logic                 cmdValid,
  output logic [WORD_BITS-1:0] cmdWord,
  output logic                 doutOut
);
  localparam logic [2:0] PIN_IDLE = 3'b010;

  logic [2:0] pinSync;
  strbT       strb;
  doutEdgeT   modeQ;

  cmdsh_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclkIn, csNIn, dinIn}),
    .syncOut(pinSync)
  );

  cmdsh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkS(pinSync[2]), .csNS(pinSync[1]),
    .strb(strb)
  );

  cmdsh_dpath #(.WORD_BITS(WORD_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(pinSync[0]),
    .modeSetValid(modeSetValid), .modeSetValue(modeSetValue),
    .modeQ(modeQ), .cmdValid(cmdValid), .cmdWord(cmdWord), .doutOut(doutOut)
  );
endmodule

// File: rtl/cmd_shift_if_chk.sv
module cmd_shift_if_chk import cmdsh_pkg::*; #(
  parameter int WORD_BITS = CMD_BITS
) (
  input logic                 clk,
  input logic                 rstN,
  input strbT                 strb,
  input doutEdgeT             modeQ,
  input logic                 cmdValid,
  input logic [WORD_BITS-1:0] cmdWord,
  input logic                 doutOut
);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_word_only_on_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdWord) |-> cmdValid);

  p_dout_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftEn || strb.fallEn) |=> $stable(doutOut));

  p_rise_mode_ignores_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == EDGE_RISE && strb.fallEn) |=> $stable(doutOut));

  p_fall_mode_ignores_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == EDGE_FALL && strb.shiftEn) |=> $stable(doutOut));

  p_dout_known_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(doutOut));
endmodule

bind cmd_shift_if cmd_shift_if_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .modeQ(modeQ),
  .cmdValid(cmdValid), .cmdWord(cmdWord), .doutOut(doutOut)
);

// File: tb/cmd_shift_if_test.sv
module cmd_shift_if_test;
  localparam int HALF = 5;
  localparam int NVEC = 7;
  // {mode, nbits[4:0], data[15:0], expected word[11:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 5'd12, 16'h0A5C, 12'hA5C},
    {1'b0, 5'd12, 16'h03F1, 12'h3F1},
    {1'b0, 5'd16, 16'hF123, 12'h123},
    {1'b0, 5'd8,  16'h00B7, 12'h3B7},
    {1'b1, 5'd12, 16'h06D2, 12'h6D2},
    {1'b1, 5'd12, 16'h00FF, 12'h0FF},
    {1'b1, 5'd4,  16'h000A, 12'hFFA}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csNIn = 1'b1, dinIn = 1'b0;
  logic modeSetValid = 1'b0, modeSetValue = 1'b0;
  logic cmdValid, doutOut;
  logic [11:0] cmdWord;

  int tests = 0, fails = 0;
  logic hist [512];
  int histCnt = 0;
  logic modeExp = 1'b0, doutExp = 1'b0, ejectExp = 1'b0;
  logic [11:0] lastWord = 12'h000;

  always #2.5 clk = ~clk;

  cmd_shift_if uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dinIn(dinIn),
    .modeSetValid(modeSetValid), .modeSetValue(modeSetValue),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .doutOut(doutOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk);
    modeSetValid = 1'b1;
    modeSetValue = m;
    @(negedge clk);
    modeSetValid = 1'b0;
    modeExp = m;
  endtask

  task automatic riseEdge(input logic b);
    logic ej;
    dinIn = b;
    waitClk(1);
    sclkIn = 1'b1;
    ej = (histCnt >= 12) ? hist[histCnt-12] : 1'b0;
    hist[histCnt] = b;
    histCnt++;
    ejectExp = ej;
    if (modeExp) doutExp = ej;
    waitClk(HALF);
    chk(doutOut === doutExp, modeExp ? "R6 dout after rise" : "R7 dout after rise",
        int'(doutOut), int'(doutExp));
  endtask

  task automatic fallEdge();
    sclkIn = 1'b0;
    if (!modeExp) doutExp = ejectExp;
    waitClk(HALF);
    chk(doutOut === doutExp, modeExp ? "R6 dout after fall" : "R7 dout after fall",
        int'(doutOut), int'(doutExp));
  endtask

  task automatic endFrame(input logic [11:0] expWord, input string req);
    int pulses = 0;
    logic [11:0] got = 12'h000;
    csNIn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cmdValid === 1'b1) begin
        pulses++;
        got = cmdWord;
      end
    end
    chk(pulses == 1, "R5 valid pulse cycles", pulses, 1);
    chk(got === expWord, req, int'(got), int'(expWord));
    lastWord = expWord;
  endtask

  task automatic frame(input int nbits, input logic [15:0] data,
                       input logic [11:0] expWord, input string req);
    @(negedge clk);
    csNIn = 1'b0;
    waitClk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      riseEdge(data[i]);
      fallEdge();
    end
    endFrame(expWord, req);
  endtask

  initial begin
    waitClk(1500000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    waitClk(4);
    chk(doutOut === 1'b0, "R1 dout after reset", int'(doutOut), 0);
    chk(cmdValid === 1'b0, "R1 valid after reset", int'(cmdValid), 0);
    rstN = 1'b1;
    waitClk(4);
    chk(cmdValid === 1'b0, "R1 no valid after release", int'(cmdValid), 0);
    frame(0, 16'h0000, 12'h000, "R1 R4 empty frame word");

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][33] !== modeExp) setMode(VEC[v][33]);
      frame(int'(VEC[v][32:28]), VEC[v][27:12], VEC[v][11:0],
            (VEC[v][32:28] >= 5'd12) ? "R3 word" : "R4 R10 short word");
    end

    // R2 R8: clocks while deselected must not shift or move dout
    dinIn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sclkIn = 1'b1;
      waitClk(HALF);
      sclkIn = 1'b0;
      waitClk(HALF);
    end
    chk(doutOut === doutExp, "R2 R8 dout held while deselected", int'(doutOut), int'(doutExp));
    frame(0, 16'h0000, lastWord, "R2 no shift while deselected");

    // R9: back to falling-edge mode, echo across the switch
    setMode(1'b0);
    frame(12, 16'h0C3A, 12'hC3A, "R9 R3 word after mode change");
    frame(12, 16'h0555, 12'h555, "R10 chained word");
    waitClk(20);
    chk(doutOut === doutExp, "R8 dout held idle", int'(doutOut), int'(doutExp));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule